// File: doc/BRIEF.md
# Over-Current Pulse-Skip Latch Sequencer

This block handles over-current events in a clocked buck converter controller. Once per switching cycle, at the end of the low-side conduction interval, a tick qualifies the flag from the low-side current comparator. A qualified flag makes the block skip the next high-side turn-on. The first such trip also opens an observation period counted in switching cycles, not system clocks.

The period is split into two windows of `WIN_CYCLES` ticks each. Trips during the first window only cause pulse skipping. A trip during the second window latches an over-current fault. The fault holds off the high side and pulls power-good low until the converter is disabled or its supply drops. If the second window passes without a trip, the sequencer returns to idle at the tick `2*WIN_CYCLES` after the first trip. A trip on that same tick starts a new observation period.

While the enable input or the supply-ok input is low, the comparator flag is ignored, all sequencer state is cleared, the high side is held off and power-good is pulled low.

Top module: `oc_pulse_skip_seq`

## Requirements
- R1: After reset, with enable and supply-ok high, `hs_inhibit_o`, `fault_o` and `pg_low_o` are all 0.
- R2: When `cyc_tick_i` and `oc_flag_i` are both high at a clock edge while active, `hs_inhibit_o` is 1 from that edge until the next tick edge. A tick with the flag low drops it back to 0 if no fault is latched.
- R3: Counting the first trip as tick 0, trips on ticks 1 to `WIN_CYCLES-1` after it cause pulse skipping but never set `fault_o`.
- R4: A trip on any tick from `WIN_CYCLES` to `2*WIN_CYCLES-1` after the first trip sets `fault_o` at that edge. While `fault_o` is 1, both `hs_inhibit_o` and `pg_low_o` are 1.
- R5: If no trip occurs on ticks `WIN_CYCLES` to `2*WIN_CYCLES-1`, the sequencer is idle again at tick `2*WIN_CYCLES`. A trip on that tick counts as a new first trip and does not latch.
- R6: A latched fault stays set through any further ticks and flags. It clears only at an edge where `en_i` or `supply_ok_i` is low.
- R7: While `en_i` or `supply_ok_i` is low, `oc_flag_i` is ignored: a trip seen while disabled opens no observation period after re-enable. `hs_inhibit_o` is 1 in this state.
- R8: Windows advance only on `cyc_tick_i`. Clocks without a tick, whatever `oc_flag_i` is doing, change neither the window position nor the skip state.
- R9: `pg_low_o` is 1 whenever a fault is latched or `en_i` or `supply_ok_i` is low, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Converter enable; low clears the fault |
| supply_ok_i | input | 1 | Supply above its undervoltage threshold; low clears the fault |
| cyc_tick_i | input | 1 | One-clock pulse at the end of each low-side conduction interval |
| oc_flag_i | input | 1 | Over-current comparator output |
| hs_inhibit_o | output | 1 | Blocks the next high-side turn-on |
| fault_o | output | 1 | Latched over-current fault |
| pg_low_o | output | 1 | Pulls power-good low |

## Verification
The hardest state to reach is the edge of the second window: a trip exactly on tick `WIN_CYCLES`, on tick `2*WIN_CYCLES-1`, or on tick `2*WIN_CYCLES`, where it must start a fresh period instead of latching. Directed sequences place a trip on each of these ticks. They also place idle clocks with a noisy flag between ticks, so a design that counts system clocks drifts out of step. A reference model of first-trip distances, fed with seeded random ticks, flags and enable drops, then covers interleavings the directed cases miss.

// File: rtl/oc_seq_pkg.sv
package oc_seq_pkg;
  typedef enum logic [1:0] {
    WIN_IDLE   = 2'd0,
    WIN_FIRST  = 2'd1,
    WIN_SECOND = 2'd2
  } win_state_e;
endpackage

// File: rtl/oc_tick_qual.sv
module oc_tick_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic tick_i,
  input  logic flag_i,
  output logic samp_o,
  output logic trip_o,
  output logic skip_o
);
  assign samp_o = tick_i & active_i;
  assign trip_o = samp_o & flag_i;

  // skip decision held for one full switching cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        skip_o <= 1'b0;
    else if (!active_i) skip_o <= 1'b0;
    else if (tick_i)    skip_o <= flag_i;
  end
endmodule

// File: rtl/oc_window_fsm.sv
module oc_window_fsm
  import oc_seq_pkg::*;
#(
  parameter int WIN_CYCLES = 8,
  localparam int CNT_W = $clog2(2 * WIN_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             hold_i,
  input  logic             samp_i,
  input  logic             trip_i,
  output logic             latch_req_o,
  output win_state_e       state_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] WinL    = CNT_W'(WIN_CYCLES);
  localparam logic [CNT_W-1:0] TwoWinL = CNT_W'(2 * WIN_CYCLES);

  win_state_e       st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, k;

  assign k = cnt_q + 1'b1;

  always_comb begin
    st_n        = st_q;
    cnt_n       = cnt_q;
    latch_req_o = 1'b0;
    if (samp_i && !hold_i) begin
      unique case (st_q)
        WIN_IDLE: begin
          if (trip_i) begin
            st_n  = WIN_FIRST;
            cnt_n = '0;
          end
        end
        WIN_FIRST, WIN_SECOND: begin
          if (k == TwoWinL) begin
            // clean run: self-reset, a trip here opens a fresh period
            st_n  = trip_i ? WIN_FIRST : WIN_IDLE;
            cnt_n = '0;
          end else if (k >= WinL) begin
            if (trip_i) begin
              latch_req_o = 1'b1;
              st_n        = WIN_IDLE;
              cnt_n       = '0;
            end else begin
              st_n  = WIN_SECOND;
              cnt_n = k;
            end
          end else begin
            cnt_n = k;
          end
        end
        default: begin
          st_n  = WIN_IDLE;
          cnt_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= WIN_IDLE;
      cnt_q <= '0;
    end else if (!active_i || hold_i) begin
      st_q  <= WIN_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  assign state_o = st_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/oc_fault_latch.sv
module oc_fault_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic set_i,
  output logic fault_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        fault_o <= 1'b0;
    else if (!active_i) fault_o <= 1'b0;
    else if (set_i)     fault_o <= 1'b1;
  end
endmodule

// File: rtl/oc_pulse_skip_seq.sv
module oc_pulse_skip_seq
  import oc_seq_pkg::*;
#(
  parameter int WIN_CYCLES = 8,
  localparam int CNT_W = $clog2(2 * WIN_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic supply_ok_i,
  input  logic cyc_tick_i,
  input  logic oc_flag_i,
  output logic hs_inhibit_o,
  output logic fault_o,
  output logic pg_low_o
);
  logic             active, samp, trip, skip, latch_req, fault;
  win_state_e       win_state;
  logic [CNT_W-1:0] win_cnt;

  assign active = en_i & supply_ok_i;

  oc_tick_qual u_qual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .tick_i   (cyc_tick_i),
    .flag_i   (oc_flag_i),
    .samp_o   (samp),
    .trip_o   (trip),
    .skip_o   (skip)
  );

  oc_window_fsm #(.WIN_CYCLES(WIN_CYCLES)) u_win (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .hold_i      (fault),
    .samp_i      (samp),
    .trip_i      (trip),
    .latch_req_o (latch_req),
    .state_o     (win_state),
    .cnt_o       (win_cnt)
  );

  oc_fault_latch u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .set_i    (latch_req),
    .fault_o  (fault)
  );

  assign fault_o      = fault;
  assign hs_inhibit_o = skip | fault | ~active;
  assign pg_low_o     = fault | ~active;
endmodule

// File: rtl/oc_pulse_skip_seq_chk.sv
module oc_pulse_skip_seq_chk #(
  parameter int WIN_CYCLES = 8,
  localparam int CNT_W = $clog2(2 * WIN_CYCLES + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             supply_ok_i,
  input logic             cyc_tick_i,
  input logic             oc_flag_i,
  input logic             hs_inhibit_o,
  input logic             fault_o,
  input logic             pg_low_o,
  input logic [CNT_W-1:0] win_cnt_i
);
  localparam logic [CNT_W-1:0] TwoWinL = CNT_W'(2 * WIN_CYCLES);

  assert_skip_on_trip_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_tick_i && oc_flag_i && en_i && supply_ok_i) |=> hs_inhibit_o);

  assert_fault_blocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (hs_inhibit_o && pg_low_o));

  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_cnt_i < TwoWinL);

  assert_fault_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && en_i && supply_ok_i) |=> fault_o);

  assert_disable_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && supply_ok_i) |=> !fault_o);

  assert_fault_on_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> $past(cyc_tick_i && oc_flag_i));

  assert_pg_disabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && supply_ok_i) |-> (pg_low_o && hs_inhibit_o));
endmodule

bind oc_pulse_skip_seq oc_pulse_skip_seq_chk #(.WIN_CYCLES(WIN_CYCLES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .supply_ok_i  (supply_ok_i),
  .cyc_tick_i   (cyc_tick_i),
  .oc_flag_i    (oc_flag_i),
  .hs_inhibit_o (hs_inhibit_o),
  .fault_o      (fault_o),
  .pg_low_o     (pg_low_o),
  .win_cnt_i    (win_cnt)
);

// File: tb/tb_oc_pulse_skip_seq.sv
`timescale 1ns/1ps
module tb_oc_pulse_skip_seq;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, sup = 1'b1, tick = 1'b0, flag = 1'b0;
  logic inh, flt, pgl;

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  bit m_armed = 0;
  bit m_fault = 0;
  bit m_skip  = 0;
  int m_k     = 0;

  always #5 clk = ~clk;

  oc_pulse_skip_seq #(.WIN_CYCLES(W)) dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .en_i         (en),
    .supply_ok_i  (sup),
    .cyc_tick_i   (tick),
    .oc_flag_i    (flag),
    .hs_inhibit_o (inh),
    .fault_o      (flt),
    .pg_low_o     (pgl)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic model_edge(bit t, bit f, bit e, bit s);
    if (!(e && s)) begin
      m_fault = 0; m_armed = 0; m_skip = 0; m_k = 0;
    end else if (t) begin
      m_skip = f;
      if (!m_fault) begin
        bit latched = 0;
        if (m_armed) begin
          m_k++;
          if (m_k >= 2 * W) m_armed = 0;
          else if (m_k >= W && f) begin
            m_fault = 1; m_armed = 0; latched = 1;
          end
        end
        if (!m_armed && !latched && f) begin
          m_armed = 1; m_k = 0;
        end
      end
    end
  endtask

  task automatic step(bit t, bit f, bit e, bit s, string req);
    tick = t; flag = f; en = e; sup = s;
    @(posedge clk);
    model_edge(t, f, e, s);
    @(negedge clk);
    chk(req, "hs_inhibit", inh, m_skip | m_fault | !(e && s));
    chk(req, "fault", flt, m_fault);
    chk(req, "pg_low", pgl, m_fault | !(e && s));
  endtask

  task automatic tk(bit f, string req);
    step(1, f, 1, 1, req);
  endtask

  task automatic quiet(int n, string req);
    for (int i = 0; i < n; i++) tk(0, req);
  endtask

  task automatic clear_all();
    step(0, 0, 0, 1, "R6");
    step(0, 0, 1, 1, "R6");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unused;
    unused = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk("R1", "hs_inhibit in reset", inh, 1'b0);
    chk("R1", "fault in reset", flt, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "hs_inhibit after reset", inh, 1'b0);
    chk("R1", "fault after reset", flt, 1'b0);
    chk("R1", "pg_low after reset", pgl, 1'b0);

    // R2: single trip skips one cycle, quiet tick restores
    tk(1, "R2");
    tk(0, "R2");
    quiet(2 * W, "R5");

    // R3: trips on ticks 1..W-1 only skip
    tk(1, "R3");
    for (int i = 1; i < W; i++) tk(1, "R3");
    quiet(W + 1, "R5");

    // R4: trip exactly on tick W latches
    tk(1, "R4");
    quiet(W - 1, "R4");
    tk(1, "R4");
    // R6: fault persists through ticks and flags
    for (int i = 0; i < 20; i++) tk(i[0], "R6");
    clear_all();

    // R4 boundary: tick 2W-1
    tk(1, "R4");
    quiet(2 * W - 2, "R4");
    tk(1, "R4");
    // R6: clear through supply instead of enable
    step(0, 1, 1, 0, "R6");
    step(0, 0, 1, 1, "R6");
    tk(0, "R6");

    // R5: trip on tick 2W is a fresh first trip
    tk(1, "R5");
    quiet(2 * W - 1, "R5");
    tk(1, "R5");
    quiet(W - 1, "R5");
    tk(1, "R4");
    clear_all();

    // R7: flagged ticks while disabled open no period
    for (int i = 0; i < 4; i++) step(1, 1, 0, 1, "R7");
    step(1, 1, 1, 0, "R7");
    quiet(W, "R7");
    tk(1, "R7");
    quiet(2 * W, "R7");

    // R8: idle clocks with noisy flag between ticks
    tk(1, "R8");
    for (int i = 1; i < W; i++) begin
      for (int j = 0; j < 5; j++) step(0, 1, 1, 1, "R8");
      tk(0, "R8");
    end
    for (int j = 0; j < 5; j++) step(0, 1, 1, 1, "R8");
    tk(1, "R8");
    clear_all();

    // random mix
    for (int i = 0; i < 6000; i++) begin
      bit t, f, e, s;
      t = ($urandom % 3) == 0;
      f = ($urandom % 6) == 0;
      e = ($urandom % 200) != 0;
      s = ($urandom % 300) != 0;
      step(t, f, e, s, "R9");
    end

    finish_run();
  end
endmodule